// File: doc/BRIEF.md
# Two-Digit Decimal Counter Modulo Sixteen

This block is a synchronous up counter that keeps its value as two decimal digits, tens and ones. It starts from 00 and counts to 15, then starts again at 00. It advances on the rising clock edge while the count enable is high. A high level on the clear input sets the count to 00 at once, whatever the clock is doing.

The digits leave the block in two forms: as 4-bit BCD codes, and as active-high seven-segment patterns ready for two display positions. A one-cycle wrap flag marks each step from 15 back to 00. Pushbutton conditioning, clock routing and display multiplexing belong to other blocks. The counter has no data stream, so every pin is plain control or status and there is no valid/ready handshake.

Top module: `bcd16_counter`

## Requirements
- R1: With `en` high and `clr` low, the count goes up by exactly one on each rising edge of `clk`.
- R2: The count runs 00, 01, ... 09, 10, ... 15 and then 00. After 09 comes tens=1, ones=0, and after 15 comes tens=0, ones=0.
- R3: `tens` is always 0 or 1 and `ones` is always in 0..9. When `tens` is 1, `ones` never exceeds 5.
- R4: While `clr` is high, `tens`, `ones` and `wrap` are 0. This takes effect without a clock edge and holds for as long as `clr` stays high, whatever `en` is.
- R5: `wrap` is high for exactly the one cycle that follows a step from 15 to 00, and it is low at every other time.
- R6: With `en` low, a rising edge leaves `tens` and `ones` unchanged and `wrap` low.
- R7: Each segment output is active high, with bit 0 = a, bit 1 = b, ... bit 6 = g. Digits 0..9 encode as 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous active-high clear to 00 |
| en | input | 1 | Count enable; holds the count when low |
| tens | output | 4 | Tens digit, BCD |
| ones | output | 4 | Ones digit, BCD |
| seg_tens | output | 7 | Segment pattern for the tens digit |
| seg_ones | output | 7 | Segment pattern for the ones digit |
| wrap | output | 1 | One-cycle pulse after the step from 15 to 00 |

## Verification
The clocked assertions are switched off while `clr` is high. They assume that `clr` and `en` change away from the rising edge, so that the hold and wrap checks always see a settled enable. They also assume that `clr` does not pulse in the middle of a step the assertions are observing. The bench changes `en` only on falling edges. It raises `clr` either on a falling edge or a short time after a rising edge, and checks the cleared outputs before the next edge. It releases `clr` on a falling edge, so no edge ever coincides with a change of either control.

// File: rtl/bcd16_pkg.sv
package bcd16_pkg;
  localparam int DIG_W = 4;
  localparam int SEG_W = 7;

  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-high segments, bit0 = a ... bit6 = g; non-decimal codes blank.
  function automatic seg_t digit_to_seg(input digit_t d);
    case (d)
      4'd0:    digit_to_seg = 7'h3F;
      4'd1:    digit_to_seg = 7'h06;
      4'd2:    digit_to_seg = 7'h5B;
      4'd3:    digit_to_seg = 7'h4F;
      4'd4:    digit_to_seg = 7'h66;
      4'd5:    digit_to_seg = 7'h6D;
      4'd6:    digit_to_seg = 7'h7D;
      4'd7:    digit_to_seg = 7'h07;
      4'd8:    digit_to_seg = 7'h7F;
      4'd9:    digit_to_seg = 7'h6F;
      default: digit_to_seg = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd16_core.sv
module bcd16_core
  import bcd16_pkg::*;
#(
  parameter int TOP_TENS = 1,
  parameter int TOP_ONES = 5
) (
  input  logic   clk,
  input  logic   clr,
  input  logic   en,
  output digit_t tens_q,
  output digit_t ones_q,
  output logic   wrap_q
);
  localparam digit_t TOP_T   = digit_t'(TOP_TENS);
  localparam digit_t TOP_O   = digit_t'(TOP_ONES);
  localparam digit_t LAST_ON = digit_t'(9);

  logic   at_top;
  logic   ones_full;
  digit_t tens_d;
  digit_t ones_d;

  always_comb begin
    at_top    = (tens_q == TOP_T) && (ones_q == TOP_O);
    ones_full = (ones_q == LAST_ON);
    tens_d    = tens_q;
    ones_d    = ones_q;
    if (at_top) begin
      tens_d = '0;
      ones_d = '0;
    end else if (ones_full) begin
      tens_d = tens_q + digit_t'(1);
      ones_d = '0;
    end else begin
      ones_d = ones_q + digit_t'(1);
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      tens_q <= '0;
      ones_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= en && at_top;
      if (en) begin
        tens_q <= tens_d;
        ones_q <= ones_d;
      end
    end
  end

  AST_ONES_DECIMAL: assert property (@(posedge clk) disable iff (clr)
    ones_q <= LAST_ON);  // R3
  AST_NO_PAST_TOP: assert property (@(posedge clk) disable iff (clr)
    !(tens_q == TOP_T && ones_q > TOP_O) && tens_q <= TOP_T);  // R3
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(tens_q) && $stable(ones_q) && !wrap_q);  // R6
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (clr)
    wrap_q |=> !wrap_q);  // R5
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (clr)
    wrap_q |-> (tens_q == '0 && ones_q == '0));  // R5
  AST_TENS_STEP: assert property (@(posedge clk) disable iff (clr)
    (en && ones_q == LAST_ON && tens_q == '0) |=> (tens_q == digit_t'(1) && ones_q == '0));  // R2
endmodule

// File: rtl/bcd16_seg7.sv
module bcd16_seg7
  import bcd16_pkg::*;
(
  input  digit_t digit,
  output seg_t   seg
);
  always_comb begin
    seg = digit_to_seg(digit);
  end

  always_comb begin
    if (digit <= digit_t'(9))
      AST_SEG_LIT: assert (seg != '0 || $isunknown(digit));  // R7
  end
endmodule

// File: rtl/bcd16_counter.sv
module bcd16_counter
  import bcd16_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       en,
  output logic [3:0] tens,
  output logic [3:0] ones,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_ones,
  output logic       wrap
);
  localparam int NUM_DIG = 2;

  digit_t dig [NUM_DIG];
  seg_t   seg [NUM_DIG];

  bcd16_core #(.TOP_TENS(1), .TOP_ONES(5)) u_core (
    .clk    (clk),
    .clr    (clr),
    .en     (en),
    .tens_q (dig[1]),
    .ones_q (dig[0]),
    .wrap_q (wrap)
  );

  for (genvar i = 0; i < NUM_DIG; i++) begin : g_dec
    bcd16_seg7 u_seg (
      .digit (dig[i]),
      .seg   (seg[i])
    );
  end

  assign tens     = dig[1];
  assign ones     = dig[0];
  assign seg_tens = seg[1];
  assign seg_ones = seg[0];
endmodule

// File: tb/bcd16_counter_tb.sv
module bcd16_counter_tb;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] tens, ones;
  logic [6:0] seg_tens, seg_ones;
  logic       wrap;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bcd16_counter u_dut (
    .clk(clk), .clr(clr), .en(en), .tens(tens), .ones(ones),
    .seg_tens(seg_tens), .seg_ones(seg_ones), .wrap(wrap)
  );

  // {en, expected value 0..15, expected wrap}
  localparam int NV = 21;
  localparam logic [5:0] VEC [NV] = '{
    {1'b1,4'd1,1'b0}, {1'b1,4'd2,1'b0}, {1'b1,4'd3,1'b0}, {1'b1,4'd4,1'b0},
    {1'b1,4'd5,1'b0}, {1'b1,4'd6,1'b0}, {1'b1,4'd7,1'b0}, {1'b1,4'd8,1'b0},
    {1'b1,4'd9,1'b0}, {1'b1,4'd10,1'b0}, {1'b1,4'd11,1'b0}, {1'b1,4'd12,1'b0},
    {1'b1,4'd13,1'b0}, {1'b1,4'd14,1'b0}, {1'b1,4'd15,1'b0}, {1'b1,4'd0,1'b1},
    {1'b1,4'd1,1'b0}, {1'b1,4'd2,1'b0}, {1'b0,4'd2,1'b0}, {1'b0,4'd2,1'b0},
    {1'b1,4'd3,1'b0}
  };

  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] pat [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return pat[d];
  endfunction

  task automatic check_state(input string req, input int val, input logic ew);
    int et = val / 10;
    int eo = val % 10;
    n_run++;
    if (tens !== 4'(et) || ones !== 4'(eo) || wrap !== ew) begin
      n_fail++;
      $display("FAIL %s: tens=%0d ones=%0d wrap=%0b expected tens=%0d ones=%0d wrap=%0b",
               req, tens, ones, wrap, et, eo, ew);
    end
    n_run++;
    if (seg_tens !== exp_seg(et) || seg_ones !== exp_seg(eo)) begin
      n_fail++;
      $display("FAIL R7 (%s): seg_tens=%h seg_ones=%h expected %h %h",
               req, seg_tens, seg_ones, exp_seg(et), exp_seg(eo));
    end
  endtask

  task automatic step(input logic e);
    @(negedge clk); en = e;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check_state("R4 reset", 0, 1'b0);
    @(negedge clk); clr = 1'b0;

    // R1 R2 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5]);
      check_state("R1/R2/R5/R6 table", int'(VEC[i][4:1]), VEC[i][0]);
    end

    // R3: full digit range over two laps
    for (int i = 0; i < 32; i++) begin
      step(1'b1);
      n_run++;
      if (ones > 4'd9 || tens > 4'd1 || (tens == 4'd1 && ones > 4'd5)) begin
        n_fail++;
        $display("FAIL R3: tens=%0d ones=%0d expected BCD 00..15", tens, ones);
      end
    end
    // count now 3 + 32 mod 16 = 3

    // R4: async clear mid-cycle, no edge
    #1 clr = 1'b1;
    #1 check_state("R4 async clear", 0, 1'b0);
    step(1'b1);
    check_state("R4 clear held with en", 0, 1'b0);
    @(negedge clk); clr = 1'b0; en = 1'b0;

    // Run to 15, clear, then confirm no wrap pulse
    for (int i = 0; i < 15; i++) step(1'b1);
    check_state("R2 reach 15", 15, 1'b0);
    @(negedge clk); clr = 1'b1; en = 1'b0;
    #1 check_state("R4 clear at 15", 0, 1'b0);
    @(negedge clk); clr = 1'b0;
    step(1'b1);
    check_state("R5 no wrap after clear", 1, 1'b0);

    // Wrap with enable dropping right after: pulse lasts one cycle
    for (int i = 0; i < 15; i++) step(1'b1);
    check_state("R5 at 0 after wrap", 0, 1'b1);
    step(1'b0);
    check_state("R5/R6 pulse ends while idle", 0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule